// File: doc/BRIEF.md
# Stack Pointer Unit for a Downward-Growing Data Stack

This block holds the stack pointer of a small processor whose stack sits in data SRAM and grows toward lower addresses. The processor core drives four one-cycle strobes: push one byte, pop one byte, push a two-byte return address, and pop a two-byte return address. For each strobe the unit gives the SRAM addresses of that access on the same cycle. On the next clock edge it moves the pointer by one or by two.

Software can see the pointer as two 8-bit halves in I/O space and can write either half. A width parameter sets how many pointer bits exist. Bits above that width read as zero, writes to them are dropped, and the pointer arithmetic wraps inside that width. On reset the pointer loads the top SRAM address, which is a parameter. Software must keep the pointer above 0x60, because the lower data addresses map the register file and I/O.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer equals the TOP_ADDR parameter masked to USED_W bits (default 0x025F), and this value reads back on io_rd_lo and io_rd_hi.
- R2: A byte push (push_b) presents the current pointer on acc_addr in the same cycle, and the pointer is one lower from the next cycle on.
- R3: A byte pop (pop_b) presents pointer+1 on acc_addr in the same cycle, and the pointer is one higher from the next cycle on.
- R4: A return-address push (push_ret) presents the low PC byte address (the pointer) on acc_addr and the high PC byte address (pointer-1) on acc_addr_hi, and the pointer drops by two.
- R5: A return-address pop (pop_ret) presents pointer+1 on acc_addr_hi (high byte, read first) and pointer+2 on acc_addr (low byte), and the pointer rises by two.
- R6: An I/O write with io_addr 0x3D replaces the low byte, and one with 0x3E replaces the high byte. The other half is unchanged. A write to any other I/O address leaves the pointer unchanged.
- R7: Pointer bits at USED_W and above (USED_W defaults to 10) read as zero and ignore writes. All pointer and address arithmetic wraps modulo 2^USED_W.
- R8: When several strobes are active together, the order is push_ret, then pop_ret, then push_b, then pop_b, and only the winner acts. An I/O write to either half in the same cycle takes the place of the pointer update. The addresses still follow the winning strobe.
- R9: With no strobe active, acc_addr shows the pointer, acc_addr_hi shows pointer-1, and the pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_b | input | 1 | Push one byte |
| pop_b | input | 1 | Pop one byte |
| push_ret | input | 1 | Push a two-byte return address |
| pop_ret | input | 1 | Pop a two-byte return address |
| io_we | input | 1 | I/O write strobe |
| io_addr | input | 6 | I/O address of the write |
| io_wdata | input | 8 | I/O write data |
| io_rd_lo | output | 8 | Low half of the pointer |
| io_rd_hi | output | 8 | High half of the pointer, unused bits zero |
| acc_addr | output | 16 | Byte address, or low PC byte address |
| acc_addr_hi | output | 16 | High PC byte address |

## Verification
A wrong pointer value first shows on the access addresses in the same cycle as the next strobe. It shows on both readback halves one cycle after the faulty update. An off-by-one in pre-increment or post-decrement appears at once as an address mismatch, even when the pointer itself is right. The stimulus crosses the top of the masked range in both directions, so a mask or wrap fault shows within one or two cycles. Strobes that collide, and a write that lands together with a stack strobe, expose a wrong priority as a pointer that differs from the model on the following cycle.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int              ADDR_W   = 16,
  parameter int              USED_W   = 10,
  parameter logic [15:0]     TOP_ADDR = 16'h025F,
  parameter logic [5:0]      LO_SEL   = 6'h3D,
  parameter logic [5:0]      HI_SEL   = 6'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_b,
  input  logic              pop_b,
  input  logic              push_ret,
  input  logic              pop_ret,
  input  logic              io_we,
  input  logic [5:0]        io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rd_lo,
  output logic [7:0]        io_rd_hi,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] acc_addr_hi
);

  localparam int HALF = ADDR_W / 2;
  localparam logic [ADDR_W-1:0] KEEP = ADDR_W'((32'd1 << USED_W) - 32'd1);
  localparam logic [ADDR_W-1:0] RST_V = ADDR_W'(TOP_ADDR) & KEEP;

  logic [ADDR_W-1:0] sp, sp_step;
  logic wr_lo, wr_hi;
  logic s_pr, s_rr, s_pb, s_qb;

  assign wr_lo = io_we && (io_addr == LO_SEL);
  assign wr_hi = io_we && (io_addr == HI_SEL);

  // fixed priority among stack strobes
  assign s_pr = push_ret;
  assign s_rr = !push_ret && pop_ret;
  assign s_pb = !push_ret && !pop_ret && push_b;
  assign s_qb = !push_ret && !pop_ret && !push_b && pop_b;

  always_comb begin
    sp_step = sp;
    if (s_pr)      sp_step = sp - ADDR_W'(2);
    else if (s_rr) sp_step = sp + ADDR_W'(2);
    else if (s_pb) sp_step = sp - ADDR_W'(1);
    else if (s_qb) sp_step = sp + ADDR_W'(1);
  end

  assign acc_addr    = (s_rr ? sp + ADDR_W'(2) : s_qb ? sp + ADDR_W'(1) : sp) & KEEP;
  assign acc_addr_hi = (s_rr ? sp + ADDR_W'(1) : sp - ADDR_W'(1)) & KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= RST_V;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) sp[HALF-1:0]      <= io_wdata & KEEP[HALF-1:0];
      if (wr_hi) sp[ADDR_W-1:HALF] <= io_wdata & KEEP[ADDR_W-1:HALF];
    end else begin
      sp <= sp_step & KEEP;
    end
  end

  assign io_rd_lo = sp[HALF-1:0];
  assign io_rd_hi = sp[ADDR_W-1:HALF];

  a_r2_push_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (s_pb && !wr_lo && !wr_hi) |=> {io_rd_hi, io_rd_lo} == (($past({io_rd_hi, io_rd_lo}) - 16'd1) & KEEP));

  a_r3_pop_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (s_qb && !wr_lo && !wr_hi) |=> {io_rd_hi, io_rd_lo} == (($past({io_rd_hi, io_rd_lo}) + 16'd1) & KEEP));

  a_r4_push_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ret && !wr_lo && !wr_hi) |=> {io_rd_hi, io_rd_lo} == (($past({io_rd_hi, io_rd_lo}) - 16'd2) & KEEP));

  a_r4_ret_pair: assert property (@(posedge clk) disable iff (!rst_n)
    push_ret |-> acc_addr_hi == ((acc_addr - 16'd1) & KEEP));

  a_r5_pop_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rr && !wr_lo && !wr_hi) |=> {io_rd_hi, io_rd_lo} == (($past({io_rd_hi, io_rd_lo}) + 16'd2) & KEEP));

  a_r6_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (io_rd_hi == $past(io_rd_hi)) && (io_rd_lo == ($past(io_wdata) & KEEP[HALF-1:0])));

  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (io_rd_hi & ~KEEP[ADDR_W-1:HALF]) == '0);

endmodule

// File: tb/test_stack_ptr_unit.sv
`timescale 1ns/100ps
module test_stack_ptr_unit;

  localparam logic [15:0] KEEP = 16'h03FF;
  localparam logic [15:0] TOPV = 16'h025F;

  logic clk = 0, rst_n = 0;
  logic push_b = 0, pop_b = 0, push_ret = 0, pop_ret = 0, io_we = 0;
  logic [5:0] io_addr = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rd_lo, io_rd_hi;
  logic [15:0] acc_addr, acc_addr_hi;

  always #2 clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .push_b(push_b), .pop_b(pop_b),
    .push_ret(push_ret), .pop_ret(pop_ret), .io_we(io_we),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rd_lo(io_rd_lo),
    .io_rd_hi(io_rd_hi), .acc_addr(acc_addr), .acc_addr_hi(acc_addr_hi));

  typedef struct {
    string ta; string ts;
    logic [15:0] a; logic [15:0] ah; logic [15:0] sp;
  } item_t;

  item_t q[$];
  logic [15:0] sp_m;
  string prev_tag;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic cmp(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit pb, qb, pr, rr, we, input logic [5:0] ad,
                      input logic [7:0] wd, input string tag);
    item_t it;
    logic [15:0] a, ah, nx;
    @(negedge clk);
    push_b = pb; pop_b = qb; push_ret = pr; pop_ret = rr;
    io_we = we; io_addr = ad; io_wdata = wd;
    // expected addresses from the winning strobe (R8 order)
    if (pr)      begin a = sp_m;         ah = sp_m - 16'd1; nx = sp_m - 16'd2; end
    else if (rr) begin a = sp_m + 16'd2; ah = sp_m + 16'd1; nx = sp_m + 16'd2; end
    else if (pb) begin a = sp_m;         ah = sp_m - 16'd1; nx = sp_m - 16'd1; end
    else if (qb) begin a = sp_m + 16'd1; ah = sp_m - 16'd1; nx = sp_m + 16'd1; end
    else         begin a = sp_m;         ah = sp_m - 16'd1; nx = sp_m;         end
    it.ta = tag; it.ts = prev_tag;
    it.a = a & KEEP; it.ah = ah & KEEP; it.sp = sp_m;
    q.push_back(it);
    if (we && (ad == 6'h3D || ad == 6'h3E)) begin
      nx = sp_m;
      if (ad == 6'h3D) nx[7:0] = wd;
      else nx[15:8] = wd;
    end
    sp_m = nx & KEEP;
    prev_tag = tag;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 6'h0, 8'h0, tag);
  endtask

  always begin
    item_t it;
    @(negedge clk);
    #1;
    if (rst_n && q.size() > 0) begin
      it = q.pop_front();
      cmp(it.ta, "acc_addr", acc_addr, it.a);
      cmp(it.ta, "acc_addr_hi", acc_addr_hi, it.ah);
      cmp(it.ts, "pointer", {io_rd_hi, io_rd_lo}, it.sp);
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    sp_m = TOPV & KEEP;
    prev_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R9");                                   // R1 reset value readback
    step(1,0,0,0,0,6'h0,8'h0,"R2");
    step(1,0,0,0,0,6'h0,8'h0,"R2");
    step(1,0,0,0,0,6'h0,8'h0,"R2");
    step(0,1,0,0,0,6'h0,8'h0,"R3");
    step(0,1,0,0,0,6'h0,8'h0,"R3");
    step(0,0,1,0,0,6'h0,8'h0,"R4");
    step(0,0,0,1,0,6'h0,8'h0,"R5");
    step(0,0,0,0,1,6'h3D,8'h80,"R6");
    step(0,0,0,0,1,6'h3E,8'h01,"R6");
    step(0,0,0,0,1,6'h3F,8'h00,"R6");             // other address ignored
    idle("R6");
    step(0,0,0,0,1,6'h3E,8'hFF,"R7");             // hi reads 0x03
    step(0,0,0,0,1,6'h3D,8'hFF,"R7");
    step(0,0,0,1,0,6'h0,8'h0,"R7");               // 0x3FF+2 wraps to 0x001
    step(1,0,0,0,0,6'h0,8'h0,"R7");               // down to 0x000
    step(0,0,1,0,0,6'h0,8'h0,"R7");               // hi addr wraps to 0x3FF
    idle("R7");
    step(0,0,0,0,1,6'h3E,8'h02,"R6");
    step(0,0,0,0,1,6'h3D,8'h40,"R6");
    step(1,1,0,0,0,6'h0,8'h0,"R8");               // push_b beats pop_b
    step(1,0,1,0,0,6'h0,8'h0,"R8");               // push_ret beats push_b
    step(0,1,0,1,0,6'h0,8'h0,"R8");               // pop_ret beats pop_b
    step(0,0,1,1,0,6'h0,8'h0,"R8");               // push_ret beats pop_ret
    step(0,0,1,0,1,6'h3D,8'h20,"R8");             // write beats strobe
    step(0,1,0,0,1,6'h3F,8'h55,"R8");             // stray write, pop acts
    idle("R9");
    idle("R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule